// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a 16-bit timer/counter made of two cascaded 8-bit count halves, with a 16-bit reload value, a run bit and a choice of count source. The source is either the system clock divided down by a fixed prescaler (timer mode) or the falling edges of an external pin (counter mode). Every step moves the count by one. A wrap loads a new value, sets a sticky overflow flag that drives the interrupt line, and flips a wrap bit that software can use as a 17th count bit.

With the down-count option off, the timer counts up only. On overflow past all ones it loads the reload value. With the option on, a synchronised direction pin picks the direction. High counts up with the same reload behaviour. Low counts down, and the step taken while the count equals the reload value is an underflow that loads all ones. Software reaches all state through a byte-wide register port. Address 0 and 1 hold the count low and high halves, 2 and 3 the reload halves, 4 the control byte and 5 the mode byte. The control byte carries run at bit 0, external source at bit 1, the overflow flag at bit 2 and the wrap bit at bit 3, which is read-only. The mode byte carries down-count enable at bit 0.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset every register reads zero, irq_o and wrap_o are low, and the count does not move.
- R2: With control bit 0 (run) set and bit 1 clear, the count takes one step every 12 clock cycles. With run clear it takes no steps.
- R3: With run and control bit 1 (external source) set, each falling edge of ext_clk_i gives exactly one step after a two-flop synchroniser. Edges seen while run is clear are lost.
- R4: With mode bit 0 clear, the count only increments. A step from 0xFFFF loads the reload value, sets the overflow flag (control bit 2) and toggles the wrap bit.
- R5: With mode bit 0 set and dir_i high, the count increments and reloads exactly as in R4.
- R6: With mode bit 0 set and dir_i low, the count decrements. A step taken while the count equals the reload value loads 0xFFFF, sets the overflow flag and toggles the wrap bit.
- R7: The wrap bit (control bit 3, also wrap_o) toggles on every overflow or underflow. It never raises irq_o, and software writes to it are ignored.
- R8: The overflow flag, mirrored on irq_o, stays set until software writes control with bit 2 clear. A wrap in the same cycle as that write leaves it set.
- R9: A write to a count half in the same cycle as a step replaces that half, cancels the step, and leaves the other half unchanged.
- R10: Reads at addresses 0 to 5 return the map above. Addresses 6 and 7 read as zero. The mode byte reads back the written bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, combinational from addr_i |
| ext_clk_i | input | 1 | External count pin, falling edge counts |
| dir_i | input | 1 | Direction pin, high counts up when down-count is enabled |
| irq_o | output | 1 | Overflow flag, interrupt request |
| wrap_o | output | 1 | Wrap bit, flips on every overflow or underflow |

## Verification
The assertions assume that ext_clk_i and dir_i reach the counter only through the synchronisers. They also assume that only one register address is written per cycle, so the two count halves are never written together. The stimulus changes both pins on the falling clock edge and holds each level for at least three cycles, so every intended edge survives synchronisation. Register writes go through a task that raises one strobe for one cycle. Count writes are placed while the prescaler is running, so some of them land on the same cycle as a step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned A_CNT_LO = 0;
   localparam int unsigned A_CNT_HI = 1;
   localparam int unsigned A_RLD_LO = 2;
   localparam int unsigned A_RLD_HI = 3;
   localparam int unsigned A_CTRL   = 4;
   localparam int unsigned A_MODE   = 5;

   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_EXT  = 1;
   localparam int unsigned B_OVF  = 2;
   localparam int unsigned B_WRAP = 3;
   localparam int unsigned B_DOWN = 0;

   typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 1");
   end

   logic sr [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sr[0] <= 1'b0;
            else         sr[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sr[i] <= 1'b0;
            else         sr[i] <= sr[i-1];
         end
      end
   end

   assign q_o = sr[STAGES-1];
endmodule

// File: rtl/tmr_step_gen.sv
module tmr_step_gen #(
   parameter int unsigned DIV         = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic ext_sel_i,
   input  logic ext_pin_i,
   output logic step_o
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("tmr_step_gen: DIV must be at least 2");
   end

   logic          ext_s, ext_d;
   logic [PW-1:0] pre_q;
   logic          pre_last, ext_fall;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ext_pin_i),
      .q_o   (ext_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ext_d <= 1'b0;
      else         ext_d <= ext_s;
   end

   assign ext_fall = ext_d & ~ext_s;
   assign pre_last = (pre_q == PW'(DIV - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 pre_q <= '0;
      else if (run_i && !ext_sel_i) pre_q <= pre_last ? '0 : pre_q + PW'(1);
      else                         pre_q <= '0;
   end

   assign step_o = run_i & (ext_sel_i ? ext_fall : pre_last);

   // R2: while timing, the prescaler advances by one each cycle until it wraps
   assert_prescale_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !ext_sel_i && !pre_last) |=> (pre_q == $past(pre_q) + PW'(1)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int unsigned HALF_W = 8,
   localparam int unsigned W     = 2 * HALF_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   input  logic              up_i,
   input  logic              lo_we_i,
   input  logic              hi_we_i,
   input  logic [HALF_W-1:0] wr_half_i,
   input  logic [W-1:0]      reload_i,
   input  logic              ovf_we_i,
   input  logic              ovf_wd_i,
   output logic [W-1:0]      cnt_o,
   output logic              ovf_o,
   output logic              wrap_o
);
   import tmr_pkg::*;

   logic [W-1:0] cnt_q;
   logic         ovf_q, wrap_q;
   logic         at_top, at_floor, cnt_we, wrap_evt;
   dir_e         dir;

   assign dir      = up_i ? DIR_UP : DIR_DOWN;
   assign at_top   = (cnt_q == {W{1'b1}});
   assign at_floor = (cnt_q == reload_i);
   assign cnt_we   = lo_we_i | hi_we_i;
   assign wrap_evt = step_i & ~cnt_we & ((dir == DIR_UP) ? at_top : at_floor);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (lo_we_i) begin
         cnt_q[HALF_W-1:0] <= wr_half_i;
      end else if (hi_we_i) begin
         cnt_q[W-1:HALF_W] <= wr_half_i;
      end else if (step_i) begin
         if (dir == DIR_UP) cnt_q <= at_top   ? reload_i    : cnt_q + W'(1);
         else               cnt_q <= at_floor ? {W{1'b1}}   : cnt_q - W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q  <= 1'b0;
         wrap_q <= 1'b0;
      end else begin
         if (wrap_evt)      ovf_q <= 1'b1;
         else if (ovf_we_i) ovf_q <= ovf_wd_i;
         if (wrap_evt)      wrap_q <= ~wrap_q;
      end
   end

   assign cnt_o  = cnt_q;
   assign ovf_o  = ovf_q;
   assign wrap_o = wrap_q;

   // R7: the wrap bit only moves together with a set overflow flag
   assert_wrap_with_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(wrap_q) |-> ovf_q);
   // R8: flag is sticky without a control write
   assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !ovf_we_i) |=> ovf_q);
   // R4: up step from all ones lands on the reload value
   assert_up_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && up_i && !cnt_we && cnt_q == {W{1'b1}}) |=> (cnt_q == $past(reload_i)));
   // R6: down step at the reload value lands on all ones
   assert_down_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !up_i && !cnt_we && cnt_q == reload_i) |=> (cnt_q == {W{1'b1}}));
   // R9: a low-half write leaves the high half alone
   assert_lo_write_keeps_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_we_i |=> (cnt_q[W-1:HALF_W] == $past(cnt_q[W-1:HALF_W])));
   // R2/R3: no step and no write means the count holds
   assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer #(
   parameter int unsigned HALF_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DIV         = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_DOWN    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [HALF_W-1:0] wr_data_i,
   output logic [HALF_W-1:0] rd_data_o,
   input  logic              ext_clk_i,
   input  logic              dir_i,
   output logic              irq_o,
   output logic              wrap_o
);
   import tmr_pkg::*;

   localparam int unsigned W = 2 * HALF_W;

   if (HALF_W < 4) begin : g_bad_half
      $error("updn_reload_timer: HALF_W must hold the control bits");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("updn_reload_timer: ADDR_W must cover six registers");
   end

   logic [W-1:0] reload_q, cnt;
   logic         run_q, ext_q, down_q, dir_s, step, ovf, wrap;
   logic         we_lo, we_hi, we_rl, we_rh, we_ctrl, we_mode;

   assign we_lo   = wr_en_i && (addr_i == ADDR_W'(A_CNT_LO));
   assign we_hi   = wr_en_i && (addr_i == ADDR_W'(A_CNT_HI));
   assign we_rl   = wr_en_i && (addr_i == ADDR_W'(A_RLD_LO));
   assign we_rh   = wr_en_i && (addr_i == ADDR_W'(A_RLD_HI));
   assign we_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
   assign we_mode = wr_en_i && (addr_i == ADDR_W'(A_MODE));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= '0;
         run_q    <= 1'b0;
         ext_q    <= 1'b0;
      end else begin
         if (we_rl) reload_q[HALF_W-1:0] <= wr_data_i;
         if (we_rh) reload_q[W-1:HALF_W] <= wr_data_i;
         if (we_ctrl) begin
            run_q <= wr_data_i[B_RUN];
            ext_q <= wr_data_i[B_EXT];
         end
      end
   end

   if (HAS_DOWN) begin : g_down
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      down_q <= 1'b0;
         else if (we_mode) down_q <= wr_data_i[B_DOWN];
      end
   end else begin : g_up_only
      assign down_q = 1'b0;
   end

   tmr_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (dir_i),
      .q_o   (dir_s)
   );

   tmr_step_gen #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_step (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q),
      .ext_sel_i(ext_q),
      .ext_pin_i(ext_clk_i),
      .step_o   (step)
   );

   tmr_count_core #(.HALF_W(HALF_W)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step),
      .up_i     (~down_q | dir_s),
      .lo_we_i  (we_lo),
      .hi_we_i  (we_hi),
      .wr_half_i(wr_data_i),
      .reload_i (reload_q),
      .ovf_we_i (we_ctrl),
      .ovf_wd_i (wr_data_i[B_OVF]),
      .cnt_o    (cnt),
      .ovf_o    (ovf),
      .wrap_o   (wrap)
   );

   always_comb begin
      rd_data_o = '0;
      case (addr_i)
         ADDR_W'(A_CNT_LO): rd_data_o = cnt[HALF_W-1:0];
         ADDR_W'(A_CNT_HI): rd_data_o = cnt[W-1:HALF_W];
         ADDR_W'(A_RLD_LO): rd_data_o = reload_q[HALF_W-1:0];
         ADDR_W'(A_RLD_HI): rd_data_o = reload_q[W-1:HALF_W];
         ADDR_W'(A_CTRL): begin
            rd_data_o[B_RUN]  = run_q;
            rd_data_o[B_EXT]  = ext_q;
            rd_data_o[B_OVF]  = ovf;
            rd_data_o[B_WRAP] = wrap;
         end
         ADDR_W'(A_MODE): rd_data_o[B_DOWN] = down_q;
         default: ;
      endcase
   end

   assign irq_o  = ovf;
   assign wrap_o = wrap;

   // R1: stopped timer never raises the interrupt by itself
   assert_stopped_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !irq_o && !we_ctrl) |=> !irq_o);
endmodule

// File: tb/tb_updn_reload_timer.sv
module tb_updn_reload_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ext_pin = 1'b1;
   logic       dir = 1'b1;
   logic       irq, wrap;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   updn_reload_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
      .wr_data_i(wdata), .rd_data_o(rdata), .ext_clk_i(ext_pin),
      .dir_i(dir), .irq_o(irq), .wrap_o(wrap)
   );

   // behavioural reference model
   int m_cnt, m_rld, m_pre;
   bit m_run, m_ext, m_down, m_ovf, m_wrap, m_extd;
   bit m_exts [2];
   bit m_dirs [2];

   function automatic int model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_cnt & 255;
         3'd1: return (m_cnt >> 8) & 255;
         3'd2: return m_rld & 255;
         3'd3: return (m_rld >> 8) & 255;
         3'd4: return {28'd0, m_wrap, m_ovf, m_ext, m_run};
         3'd5: return {31'd0, m_down};
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin : mdl
      int  ncnt;
      bit  tick, up, evt, cwe;
      if (!rst_n) begin
         m_cnt = 0; m_rld = 0; m_pre = 0;
         m_run = 0; m_ext = 0; m_down = 0; m_ovf = 0; m_wrap = 0; m_extd = 0;
         m_exts[0] = 0; m_exts[1] = 0; m_dirs[0] = 0; m_dirs[1] = 0;
      end else begin
         tick = m_run && (m_ext ? (m_extd && !m_exts[1]) : (m_pre == 11));
         up   = !m_down || m_dirs[1];
         cwe  = we && (addr == 3'd0 || addr == 3'd1);
         evt  = 0;
         ncnt = m_cnt;
         if (we && addr == 3'd0)      ncnt = (m_cnt & 32'hFF00) | wdata;
         else if (we && addr == 3'd1) ncnt = (m_cnt & 32'h00FF) | (int'(wdata) << 8);
         else if (tick) begin
            if (up) begin
               if (m_cnt == 65535) begin ncnt = m_rld; evt = 1; end
               else ncnt = m_cnt + 1;
            end else begin
               if (m_cnt == m_rld) begin ncnt = 65535; evt = 1; end
               else ncnt = (m_cnt + 65535) & 65535;
            end
         end
         if (cwe) evt = 0;
         if (we && addr == 3'd4) m_ovf = wdata[2];
         if (evt) begin m_ovf = 1; m_wrap = !m_wrap; end
         if (m_run && !m_ext) m_pre = (m_pre == 11) ? 0 : m_pre + 1;
         else m_pre = 0;
         if (we && addr == 3'd2) m_rld = (m_rld & 32'hFF00) | wdata;
         if (we && addr == 3'd3) m_rld = (m_rld & 32'h00FF) | (int'(wdata) << 8);
         if (we && addr == 3'd4) begin m_run = wdata[0]; m_ext = wdata[1]; end
         if (we && addr == 3'd5) m_down = wdata[0];
         m_cnt = ncnt;
         m_extd = m_exts[1]; m_exts[1] = m_exts[0]; m_exts[0] = ext_pin;
         m_dirs[1] = m_dirs[0]; m_dirs[0] = dir;
      end
   end

   // per-cycle comparison against the model
   always begin
      @(negedge clk);
      #2;
      if (cmp_en) begin
         checks++;
         if (int'(rdata) != model_read(addr) || irq != m_ovf || wrap != m_wrap) begin
            errors++;
            $display("FAIL %s cycle compare addr=%0d: rd=%0h irq=%0b wrap=%0b expected rd=%0h irq=%0b wrap=%0b",
                     cur_req, addr, rdata, irq, wrap, model_read(addr), m_ovf, m_wrap);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 3'(a); wdata = 8'(d); we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      addr = 3'(a);
      #3;
      v = int'(rdata);
   endtask

   task automatic pulse();
      @(negedge clk); ext_pin = 1'b0;
      repeat (3) @(negedge clk);
      ext_pin = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      #4_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // R1 reset state
      cur_req = "R1";
      for (int a = 0; a < 6; a++) begin rd(a, v); chk("R1", v, 0); end
      chk("R1", int'(irq), 0);
      chk("R1", int'(wrap), 0);
      repeat (30) @(negedge clk);
      rd(0, v); chk("R1", v, 0);

      // R10 unmapped addresses
      cur_req = "R10";
      rd(6, v); chk("R10", v, 0);
      rd(7, v); chk("R10", v, 0);

      // R2 timer mode
      cur_req = "R2";
      wr(2, 8'h34); wr(3, 8'h12);
      wr(0, 0); wr(1, 0);
      wr(4, 8'h01);
      repeat (120) @(negedge clk);
      rd(0, v);
      chk("R2", int'(v >= 9 && v <= 11), 1);
      wr(4, 8'h00);
      rd(0, v);
      repeat (40) @(negedge clk);
      rd(0, v2); chk("R2", v2, v);

      // R4 up overflow with reload
      cur_req = "R4";
      wr(0, 8'hFE); wr(1, 8'hFF);
      wr(4, 8'h01);
      repeat (41) @(negedge clk);
      chk("R4", int'(irq), 1);
      chk("R4", int'(wrap), 1);
      rd(1, v); chk("R4", v, 8'h12);

      // R8 sticky flag and clear
      cur_req = "R8";
      repeat (30) @(negedge clk);
      chk("R8", int'(irq), 1);
      wr(4, 8'h01);
      chk("R8", int'(irq), 0);
      wr(4, 8'h00);

      // R7 wrap bit not writable, no interrupt from it
      cur_req = "R7";
      wr(4, 8'h08);
      chk("R7", int'(wrap), 1);
      chk("R7", int'(irq), 0);

      // R3 counter mode
      cur_req = "R3";
      wr(0, 0); wr(1, 0);
      wr(4, 8'h03);
      for (int i = 0; i < 5; i++) pulse();
      repeat (4) @(negedge clk);
      rd(0, v); chk("R3", v, 5);
      wr(4, 8'h02);
      for (int i = 0; i < 3; i++) pulse();
      repeat (4) @(negedge clk);
      rd(0, v); chk("R3", v, 5);

      // R6 down counting, underflow at reload
      cur_req = "R6";
      wr(5, 8'h01);
      dir = 1'b0;
      wr(2, 8'h03); wr(3, 8'h00);
      wr(0, 8'h05); wr(1, 8'h00);
      wr(4, 8'h03);
      repeat (4) @(negedge clk);
      pulse(); pulse();
      repeat (4) @(negedge clk);
      rd(0, v); chk("R6", v, 3);
      chk("R6", int'(irq), 0);
      pulse();
      repeat (4) @(negedge clk);
      rd(0, v); chk("R6", v, 8'hFF);
      rd(1, v); chk("R6", v, 8'hFF);
      chk("R6", int'(irq), 1);
      chk("R6", int'(wrap), 0);
      rd(5, v); chk("R10", v, 1);

      // R5 direction pin high counts up with reload
      cur_req = "R5";
      dir = 1'b1;
      repeat (4) @(negedge clk);
      pulse();
      repeat (4) @(negedge clk);
      rd(0, v); chk("R5", v, 3);
      pulse();
      repeat (4) @(negedge clk);
      rd(0, v); chk("R5", v, 4);
      chk("R7", int'(wrap), 1);

      // R9 count half writes
      cur_req = "R9";
      wr(4, 8'h00); wr(5, 8'h00);
      wr(0, 8'h10); wr(1, 8'hAB);
      rd(1, v); chk("R9", v, 8'hAB);
      rd(0, v); chk("R9", v, 8'h10);
      wr(4, 8'h01);
      for (int i = 0; i < 40; i++) begin
         repeat (i % 7) @(negedge clk);
         wr(i % 2, (i * 37) & 255);
      end
      wr(4, 8'h00);
      rd(2, v); chk("R10", v, 3);

      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule